// File: doc/BRIEF.md
# PAL Output Macrocell

This block models one output slice of a sum-of-products programmable logic device. A set of product terms is formed from a shared input bus plus a single feedback line. Each term takes its literals from a fuse mask that the designer can program. A fixed OR gate merges a limited number of these terms into one sum. The sum then goes through per-pin options. It can pass straight through or be held in a clocked flip-flop. It can be inverted. Its driver can be gated by a dedicated enable term. The whole pin can also be turned around to act as an input.

The bidirectional pin is split into three signals: the value seen on the pad (`pin_in`), the value the cell would drive (`pin_out`) and the driver enable (`pin_oe`). The feedback line `fb_out` is also the extra literal pair seen by the cell's own product terms. It lets the cell serve as a small state machine when the flip-flop is selected, or read an external signal when the pin is an input.

Top module: `pal_output_cell`

## Requirements
- R1: A product term is the AND of every literal whose fuse bit is set. In the mask, bit 2k selects input k true and bit 2k+1 selects input k complemented. Input index IN_W is the feedback line. A term whose mask is all zero evaluates to 0.
- R2: The cell sum is the OR of exactly NTERM product terms (default 8). Term t uses mask bits [t*LIT_W +: LIT_W] of `cfg_and_fuse`, where LIT_W = 2*(IN_W+1).
- R3: With `cfg_registered`=0, `pin_out` follows the sum in the same cycle.
- R4: With `cfg_registered`=1, the sum is captured on the rising clock edge. `pin_out` holds that value until the next edge, whatever the inputs do in between.
- R5: While `rst_n` is low at a rising edge, the flip-flop is cleared to 0 (synchronous, active low).
- R6: `cfg_invert`=1 complements `pin_out`. The inversion sits after the flip-flop in registered mode.
- R7: In output mode with `cfg_tristate`=0, `pin_oe` is 1.
- R8: In output mode with `cfg_tristate`=1, `pin_oe` equals a separate enable term. That term uses `cfg_oe_fuse` with the same literal encoding as R1, and an empty mask gives 0.
- R9: With `cfg_pin_input`=1, `pin_oe` is 0 and `fb_out` equals `pin_in`, whatever the other options are.
- R10: In output mode, `fb_out` is the flip-flop value when registered and `pin_in` when combinational.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the macrocell flip-flop |
| rst_n | input | 1 | Synchronous active-low reset of the flip-flop |
| in_bus | input | IN_W | Shared inputs feeding the AND array |
| pin_in | input | 1 | Value present on the pad |
| cfg_and_fuse | input | NTERM*LIT_W | Literal masks of the sum terms |
| cfg_oe_fuse | input | LIT_W | Literal mask of the enable term |
| cfg_invert | input | 1 | Complement the output |
| cfg_registered | input | 1 | Select the flip-flop path |
| cfg_tristate | input | 1 | Let the enable term control the driver |
| cfg_pin_input | input | 1 | Use the pin as an input |
| pin_out | output | 1 | Value the cell drives onto the pad |
| pin_oe | output | 1 | Driver enable for the pad |
| fb_out | output | 1 | Feedback line into the AND array |

## Verification
The bench programs empty masks and checks that they produce 0. An array that treated an unconnected term as always true would force the sum high. In registered mode it changes the inputs between clock edges and checks that `pin_out` holds. A cell that leaked the combinational sum would fail there. It also applies inversion with the flip-flop selected, where inverting before the register would break the reset value. It builds a toggle from the feedback literal in registered mode, which only counts correctly when feedback comes from the flip-flop. Input mode is combined with tristate disabled to catch a cell that still drives the pin.

// File: rtl/pal_cell_pkg.sv
// Package: shared mode type and width helper for the output macrocell.
// Assumes every user of the package applies the same literal encoding:
// two mask bits per input (true, complemented), feedback as the last input.
package pal_cell_pkg;

    // Option bits of one macrocell, gathered for internal routing.
    typedef struct packed {
        logic invert;
        logic registered;
        logic tristate;
        logic pin_input;
    } pal_mode_t;

    // Number of mask bits per product term for a given bus width.
    function automatic int unsigned lit_width(input int unsigned in_w);
        return 2 * (in_w + 1);
    endfunction

endpackage

// File: rtl/pal_and_plane.sv
// Module: programmable AND array.
// Builds NT product terms from IN_W bus inputs plus one feedback input.
// Each term has its own literal mask. A term with no literal selected
// yields 0, so an unused term never forces the OR high.
module pal_and_plane #(
    parameter int unsigned IN_W = 8,
    parameter int unsigned NT   = 8,
    localparam int unsigned LIT_W = pal_cell_pkg::lit_width(IN_W)
) (
    input  logic [IN_W-1:0]     in_i,
    input  logic                fb_i,
    input  logic [NT*LIT_W-1:0] mask_i,
    output logic [NT-1:0]       term_o
);

    logic [LIT_W-1:0] lit;

    // Literal pairs for the bus inputs: true at even bit, complement at odd.
    for (genvar k = 0; k < IN_W; k++) begin : g_lit
        assign lit[2*k]   = in_i[k];
        assign lit[2*k+1] = ~in_i[k];
    end

    // Literal pair for the feedback line, placed after the bus inputs.
    assign lit[2*IN_W]   = fb_i;
    assign lit[2*IN_W+1] = ~fb_i;

    // One AND gate per term; masked-off literals read as 1, empty term reads 0.
    for (genvar t = 0; t < NT; t++) begin : g_term
        logic [LIT_W-1:0] m;
        assign m         = mask_i[t*LIT_W +: LIT_W];
        assign term_o[t] = (|m) & (&(lit | ~m));
    end

endmodule

// File: rtl/pal_or_sum.sv
// Module: fixed OR gate.
// Merges a predefined group of NT product terms into one sum; nothing here
// is programmable. Assumes the terms arrive already masked.
module pal_or_sum #(
    parameter int unsigned NT = 8
) (
    input  logic [NT-1:0] term_i,
    output logic          sum_o
);

    // Hard-wired OR over the term group.
    always_comb begin
        sum_o = 1'b0;
        for (int t = 0; t < NT; t++) begin
            sum_o = sum_o | term_i[t];
        end
    end

endmodule

// File: rtl/pal_out_ctl.sv
// Module: output option stage of the macrocell.
// Selects the combinational or registered sum, applies inversion after
// the flip-flop, forms the driver enable and picks the feedback source.
// Assumes a synchronous active-low reset that clears only the flip-flop.
module pal_out_ctl
    import pal_cell_pkg::*;
(
    input  logic      clk_i,
    input  logic      rst_ni,
    input  logic      sum_i,
    input  logic      oe_term_i,
    input  logic      pin_in_i,
    input  pal_mode_t mode_i,
    output logic      pin_out_o,
    output logic      pin_oe_o,
    output logic      fb_o
);

    logic q_r;
    logic core;

    // Macrocell flip-flop: captures the sum every rising edge.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            q_r <= 1'b0;
        end else begin
            q_r <= sum_i;
        end
    end

    // Output value: path select first, then optional inversion.
    always_comb begin
        core      = mode_i.registered ? q_r : sum_i;
        pin_out_o = core ^ mode_i.invert;
    end

    // Driver enable: off for input pins, enable term when tristate is used.
    always_comb begin
        if (mode_i.pin_input) begin
            pin_oe_o = 1'b0;
        end else if (mode_i.tristate) begin
            pin_oe_o = oe_term_i;
        end else begin
            pin_oe_o = 1'b1;
        end
    end

    // Feedback source: pad for input or combinational pins, flip-flop otherwise.
    always_comb begin
        if (!mode_i.pin_input && mode_i.registered) begin
            fb_o = q_r;
        end else begin
            fb_o = pin_in_i;
        end
    end

    AST_REG_CAPTURE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $past(rst_ni) |-> (q_r == $past(sum_i)));                       // R4
    AST_RESET_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$past(rst_ni) |-> (q_r == 1'b0));                              // R5
    AST_REG_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mode_i.registered && $stable(mode_i.invert) && $stable(q_r))
        |-> $stable(pin_out_o));                                        // R4

endmodule

// File: rtl/pal_output_cell.sv
// Module: top of one PAL-style output macrocell.
// A programmable AND array over the input bus and the feedback line feeds
// a fixed OR of NTERM terms; a second one-term array forms the driver
// enable. The option stage then applies register, invert, tristate and
// pin direction. Assumes configuration inputs are held static by the user.
module pal_output_cell
    import pal_cell_pkg::*;
#(
    parameter int unsigned IN_W  = 8,
    parameter int unsigned NTERM = 8,
    localparam int unsigned LIT_W = pal_cell_pkg::lit_width(IN_W)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [IN_W-1:0]        in_bus,
    input  logic                   pin_in,
    input  logic [NTERM*LIT_W-1:0] cfg_and_fuse,
    input  logic [LIT_W-1:0]       cfg_oe_fuse,
    input  logic                   cfg_invert,
    input  logic                   cfg_registered,
    input  logic                   cfg_tristate,
    input  logic                   cfg_pin_input,
    output logic                   pin_out,
    output logic                   pin_oe,
    output logic                   fb_out
);

    pal_mode_t        mode;
    logic [NTERM-1:0] terms;
    logic             oe_term;
    logic             sum;

    // Gather option bits into the shared mode type.
    always_comb begin
        mode.invert     = cfg_invert;
        mode.registered = cfg_registered;
        mode.tristate   = cfg_tristate;
        mode.pin_input  = cfg_pin_input;
    end

    pal_and_plane #(.IN_W(IN_W), .NT(NTERM)) u_sum_plane (
        .in_i   (in_bus),
        .fb_i   (fb_out),
        .mask_i (cfg_and_fuse),
        .term_o (terms)
    );

    pal_and_plane #(.IN_W(IN_W), .NT(1)) u_oe_plane (
        .in_i   (in_bus),
        .fb_i   (fb_out),
        .mask_i (cfg_oe_fuse),
        .term_o (oe_term)
    );

    pal_or_sum #(.NT(NTERM)) u_or (
        .term_i (terms),
        .sum_o  (sum)
    );

    pal_out_ctl u_ctl (
        .clk_i     (clk),
        .rst_ni    (rst_n),
        .sum_i     (sum),
        .oe_term_i (oe_term),
        .pin_in_i  (pin_in),
        .mode_i    (mode),
        .pin_out_o (pin_out),
        .pin_oe_o  (pin_oe),
        .fb_o      (fb_out)
    );

    AST_INPUT_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_pin_input |-> (!pin_oe && (fb_out == pin_in)));             // R9
    AST_OE_FORCED: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_pin_input && !cfg_tristate) |-> pin_oe);                  // R7
    AST_OE_TERM: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_pin_input && cfg_tristate) |-> (pin_oe == oe_term));      // R8
    AST_COMB_PATH: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_registered |-> (pin_out == (sum ^ cfg_invert)));           // R3
    AST_FB_FROM_REG: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_registered && !cfg_pin_input)
        |-> (fb_out == (pin_out ^ cfg_invert)));                        // R10

endmodule

// File: tb/pal_output_cell_tb_top.sv
`timescale 1ns/1ps
module pal_output_cell_tb_top;

    localparam int IN_W = 8;
    localparam int NT   = 8;
    localparam int LW   = 2 * (IN_W + 1);

    logic              clk = 1'b0;
    logic              rst_n;
    logic [IN_W-1:0]   in_bus;
    logic              pin_in;
    logic [NT*LW-1:0]  and_fuse;
    logic [LW-1:0]     oe_fuse;
    logic              c_inv, c_reg, c_tri, c_inp;
    logic              pin_out, pin_oe, fb_out;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    pal_output_cell #(.IN_W(IN_W), .NTERM(NT)) dut_i (
        .clk            (clk),
        .rst_n          (rst_n),
        .in_bus         (in_bus),
        .pin_in         (pin_in),
        .cfg_and_fuse   (and_fuse),
        .cfg_oe_fuse    (oe_fuse),
        .cfg_invert     (c_inv),
        .cfg_registered (c_reg),
        .cfg_tristate   (c_tri),
        .cfg_pin_input  (c_inp),
        .pin_out        (pin_out),
        .pin_oe         (pin_oe),
        .fb_out         (fb_out)
    );

    function automatic logic [LW-1:0] pos(input int k);
        return LW'(1) << (2 * k);
    endfunction

    function automatic logic [LW-1:0] neg(input int k);
        return LW'(1) << (2 * k + 1);
    endfunction

    // Reference term per R1.
    function automatic logic ref_term(input logic [LW-1:0] m,
                                      input logic [IN_W-1:0] x, input logic f);
        logic [LW-1:0] l;
        for (int k = 0; k < IN_W; k++) begin
            l[2*k]   = x[k];
            l[2*k+1] = ~x[k];
        end
        l[2*IN_W]   = f;
        l[2*IN_W+1] = ~f;
        return (m != '0) && ((l & m) == m);
    endfunction

    // Reference sum per R2.
    function automatic logic ref_sum(input logic [IN_W-1:0] x, input logic f);
        logic s = 1'b0;
        for (int t = 0; t < NT; t++) s = s | ref_term(and_fuse[t*LW +: LW], x, f);
        return s;
    endfunction

    task automatic check(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic clear_cfg();
        and_fuse = '0; oe_fuse = '0;
        c_inv = 0; c_reg = 0; c_tri = 0; c_inp = 0;
        in_bus = '0; pin_in = 0;
    endtask

    task automatic set_term(input int t, input logic [LW-1:0] m);
        and_fuse[t*LW +: LW] = m;
    endtask

    // R5: reset clears the flip-flop, also after it held a 1.
    task automatic t_reset();
        @(negedge clk);
        clear_cfg(); c_reg = 1;
        set_term(0, pos(0));
        rst_n = 0;
        @(posedge clk); #1;
        check("R5 reset state", pin_out, 1'b0);
        @(negedge clk); rst_n = 1; in_bus = 8'h01;
        @(posedge clk); #1;
        check("R4 capture one", pin_out, 1'b1);
        @(negedge clk); rst_n = 0;
        @(posedge clk); #1;
        check("R5 reset mid-run", pin_out, 1'b0);
        @(negedge clk); rst_n = 1;
    endtask

    // R1/R2/R3: combinational sums over several patterns and masks.
    task automatic t_comb();
        logic [IN_W-1:0] pats [6] = '{8'h00, 8'h01, 8'h03, 8'h80, 8'h04, 8'h7E};
        @(negedge clk);
        clear_cfg();
        for (int i = 0; i < 6; i++) begin
            in_bus = pats[i]; #1;
            check("R1 empty masks give 0", pin_out, 1'b0);
        end
        set_term(0, pos(0) | neg(1));
        set_term(3, pos(7));
        set_term(7, pos(2) | pos(5));
        for (int i = 0; i < 6; i++) begin
            in_bus = pats[i]; #1;
            check("R2 R3 comb sum", pin_out, ref_sum(pats[i], pin_in));
        end
        c_inv = 1;
        for (int i = 0; i < 6; i++) begin
            in_bus = pats[i]; #1;
            check("R6 comb invert", pin_out, ~ref_sum(pats[i], pin_in));
        end
    endtask

    // R4/R6: registered path holds between edges; inversion after the flop.
    task automatic t_reg();
        @(negedge clk);
        clear_cfg(); c_reg = 1; set_term(0, pos(4));
        in_bus = 8'h10;
        @(posedge clk); #1;
        check("R4 captured", pin_out, 1'b1);
        @(negedge clk); in_bus = 8'h00; #1;
        check("R4 hold before edge", pin_out, 1'b1);
        @(posedge clk); #1;
        check("R4 next capture", pin_out, 1'b0);
        @(negedge clk); c_inv = 1; #1;
        check("R6 invert after flop", pin_out, 1'b1);
        rst_n = 0;
        @(posedge clk); #1;
        check("R6 R5 inverted reset", pin_out, 1'b1);
        @(negedge clk); rst_n = 1;
    endtask

    // R7/R8: driver enable with and without the enable term.
    task automatic t_oe();
        @(negedge clk);
        clear_cfg(); oe_fuse = pos(3); #1;
        check("R7 oe forced", pin_oe, 1'b1);
        c_tri = 1; #1;
        check("R8 oe term low", pin_oe, 1'b0);
        in_bus = 8'h08; #1;
        check("R8 oe term high", pin_oe, 1'b1);
        oe_fuse = '0; #1;
        check("R8 empty oe term", pin_oe, 1'b0);
    endtask

    // R9: input mode disables the driver and routes the pad to feedback.
    task automatic t_input();
        @(negedge clk);
        clear_cfg(); c_inp = 1; c_reg = 1;
        set_term(0, pos(IN_W));
        pin_in = 1; #1;
        check("R9 oe off", pin_oe, 1'b0);
        check("R9 fb is pad", fb_out, 1'b1);
        c_reg = 0; #1;
        check("R1 feedback literal", pin_out, 1'b1);
        pin_in = 0; #1;
        check("R9 fb follows pad", fb_out, 1'b0);
        check("R1 feedback literal low", pin_out, 1'b0);
    endtask

    // R10: feedback sources in output mode; registered toggle.
    task automatic t_feedback();
        logic exp_q = 1'b0;
        @(negedge clk);
        clear_cfg(); pin_in = 1; #1;
        check("R10 comb fb is pad", fb_out, 1'b1);
        rst_n = 0; c_reg = 1; set_term(0, neg(IN_W));
        @(posedge clk);
        @(negedge clk); rst_n = 1; pin_in = 0;
        for (int i = 0; i < 4; i++) begin
            @(posedge clk); #1;
            exp_q = ~exp_q;
            check("R10 reg toggle", pin_out, exp_q);
            check("R10 fb is flop", fb_out, exp_q);
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        clear_cfg();
        rst_n = 0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1;
        t_reset();
        t_comb();
        t_reg();
        t_oe();
        t_input();
        t_feedback();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule